// File: doc/BRIEF.md
# Operand-Holding Reservation Station with Same-Cycle Bypass

This block queues instructions for one function unit and keeps their source operand values inside the station. A source that is still being produced is held as a producer tag in the very register that will later hold its value. While an instruction waits, the station watches a single result-broadcast bus. When a broadcast tag matches a pending source, the broadcast value is written into that source field. An optional constant travels with the instruction and goes to the function unit once, when the instruction issues.

Each cycle the station picks one instruction to send to the function unit. It chooses the oldest stored instruction whose operands are complete, counting values arriving on the broadcast bus in that same cycle. If no stored instruction can go and the instruction being inserted already has both operands, the inserted instruction skips entry storage and goes to the issue register in its insert cycle. In that case the station costs it no extra cycle.

The issue port is a registered stage feeding the function unit. A dependent instruction can therefore issue in the cycle right after its producer's result is broadcast. Insertion is refused while every entry is occupied.

Top module: `vrs_station`

## Requirements
- R1: After synchronous reset, `iss_valid` and `full` are 0 and no entry is occupied.
- R2: An inserted instruction with both sources ready, accepted while no stored instruction can issue, appears on the issue port in the next cycle for exactly one cycle and occupies no entry.
- R3: A source operand with its ready bit at 1 carries a value. With the ready bit at 0, bits [TAG_W-1:0] of the data field carry the producer tag and the upper bits are ignored for matching.
- R4: A broadcast whose tag matches a waiting source writes the broadcast value into it. An instruction completed this way issues in the cycle after the broadcast. A non-matching broadcast wakes nothing.
- R5: A broadcast in the same cycle as an insert is captured by the inserted instruction and counts toward its bypass eligibility.
- R6: At most one instruction issues per cycle. It is the oldest stored instruction whose operands are complete, and its operands, opcode and destination tag on the issue port equal those inserted or captured. The issue port is registered: a selection in cycle t is visible in cycle t+1.
- R7: A stored instruction that can issue takes priority over a bypass. The inserted instruction is then stored and issues later.
- R8: `full` is 1 exactly when all ENTRIES entries are occupied. An insert presented while `full` is 1 is ignored: it is never issued, changes no state, and is ignored even in a cycle in which an entry issues.
- R9: An entry is freed on the clock edge that moves its instruction into the issue register, so `full` falls in the cycle its issue becomes visible.
- R10: The constant enable and value reach the issue port unchanged, and every accepted instruction issues exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Insert request |
| ins_op | input | OP_W | Opcode of the inserted instruction |
| ins_a_rdy | input | 1 | Source A holds a value (1) or a tag (0) |
| ins_a_data | input | DATA_W | Source A value, or tag in the low TAG_W bits |
| ins_b_rdy | input | 1 | Source B holds a value (1) or a tag (0) |
| ins_b_data | input | DATA_W | Source B value, or tag in the low TAG_W bits |
| ins_imm_en | input | 1 | Constant present |
| ins_imm | input | DATA_W | Constant value |
| ins_dst | input | TAG_W | Destination tag |
| full | output | 1 | All entries occupied; inserts are ignored |
| bc_valid | input | 1 | Result broadcast valid |
| bc_tag | input | TAG_W | Tag of the broadcast result |
| bc_val | input | DATA_W | Broadcast result value |
| iss_valid | output | 1 | Issue register holds an instruction |
| iss_op | output | OP_W | Issued opcode |
| iss_a | output | DATA_W | Issued source A value |
| iss_b | output | DATA_W | Issued source B value |
| iss_imm_en | output | 1 | Issued constant present |
| iss_imm | output | DATA_W | Issued constant |
| iss_dst | output | TAG_W | Issued destination tag |

## Verification
The assertions assume the surrounding core keeps its tags consistent. A tag is broadcast at most once while instructions wait on it, it is never reused until its result is broadcast, and no insert names a producer tag that was broadcast before that insert. The occupancy check also assumes the function unit accepts the issue register every cycle. The stimulus builds random dependency chains that respect these rules. Sources are drawn only from tags that are still in flight. A destination tag is allocated only when the insert is accepted, and it is freed only after its broadcast. Broadcasts are issued only for instructions that the reference model has already issued.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
  parameter int DATA_W = 32;
  parameter int TAG_W  = 4;
  parameter int OP_W   = 6;

  // A source: when rdy is 0 the low TAG_W bits of data name the producer.
  typedef struct packed {
    logic              rdy;
    logic [DATA_W-1:0] data;
  } opnd_t;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    opnd_t             a;
    opnd_t             b;
    logic              imm_en;
    logic [DATA_W-1:0] imm;
    logic [TAG_W-1:0]  dst;
  } uop_t;

  // Merge a broadcast result into a pending source.
  function automatic opnd_t snoop(opnd_t o, logic hit_v,
                                  logic [TAG_W-1:0] t, logic [DATA_W-1:0] v);
    opnd_t r;
    r = o;
    if (!o.rdy && hit_v && (o.data[TAG_W-1:0] == t)) begin
      r.rdy  = 1'b1;
      r.data = v;
    end
    return r;
  endfunction
endpackage

// File: rtl/vrs_entry.sv
module vrs_entry
  import vrs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  uop_t              alloc_uop,
  input  logic              drop,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              busy,
  output logic              ready,
  output uop_t              live
);
  uop_t held;

  // Current view of the entry including a broadcast arriving this cycle.
  always_comb begin
    live   = held;
    live.a = snoop(held.a, bc_valid, bc_tag, bc_val);
    live.b = snoop(held.b, bc_valid, bc_tag, bc_val);
  end

  assign ready = busy && live.a.rdy && live.b.rdy;

  always_ff @(posedge clk) begin
    if (rst)        busy <= 1'b0;
    else if (drop)  busy <= 1'b0;
    else if (alloc) busy <= 1'b1;
  end

  // Payload needs no reset: busy qualifies it.
  always_ff @(posedge clk) begin
    if (alloc) held <= alloc_uop;
    else       held <= live;
  end
endmodule

// File: rtl/vrs_age_pick.sv
module vrs_age_pick #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  // older[i][j] is 1 when entry i was written before entry j.
  logic [N-1:0] older [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      older <= '{default: '0};
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (i != j) begin
            if (alloc[i])      older[i][j] <= 1'b0;
            else if (alloc[j]) older[i][j] <= 1'b1;
          end
        end
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_grant
    logic [N-1:0] beaten;
    always_comb begin
      for (int j = 0; j < N; j++) beaten[j] = req[j] && older[j][g];
    end
    assign grant[g] = req[g] && !(|beaten);
  end
endmodule

// File: rtl/vrs_station.sv
module vrs_station
  import vrs_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [OP_W-1:0]   ins_op,
  input  logic              ins_a_rdy,
  input  logic [DATA_W-1:0] ins_a_data,
  input  logic              ins_b_rdy,
  input  logic [DATA_W-1:0] ins_b_data,
  input  logic              ins_imm_en,
  input  logic [DATA_W-1:0] ins_imm,
  input  logic [TAG_W-1:0]  ins_dst,
  output logic              full,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              iss_valid,
  output logic [OP_W-1:0]   iss_op,
  output logic [DATA_W-1:0] iss_a,
  output logic [DATA_W-1:0] iss_b,
  output logic              iss_imm_en,
  output logic [DATA_W-1:0] iss_imm,
  output logic [TAG_W-1:0]  iss_dst
);
  localparam int UOP_W = $bits(uop_t);

  uop_t               ins_raw, ins_live, pick_uop;
  uop_t               slot_live [ENTRIES];
  logic [ENTRIES-1:0] slot_busy, slot_ready, slot_grant, slot_alloc, free_oh;
  logic [UOP_W-1:0]   pick_bits;
  logic               any_grant, ins_ok, bypass, issue_go;
  logic [1:0]         pick_rdy;

  // Incoming instruction, with a same-cycle broadcast merged in.
  always_comb begin
    ins_raw.op     = ins_op;
    ins_raw.a.rdy  = ins_a_rdy;
    ins_raw.a.data = ins_a_data;
    ins_raw.b.rdy  = ins_b_rdy;
    ins_raw.b.data = ins_b_data;
    ins_raw.imm_en = ins_imm_en;
    ins_raw.imm    = ins_imm;
    ins_raw.dst    = ins_dst;
    ins_live       = ins_raw;
    ins_live.a     = snoop(ins_raw.a, bc_valid, bc_tag, bc_val);
    ins_live.b     = snoop(ins_raw.b, bc_valid, bc_tag, bc_val);
  end

  assign full      = &slot_busy;
  assign any_grant = |slot_grant;
  assign ins_ok    = ins_valid && !full;
  assign bypass    = ins_ok && !any_grant && ins_live.a.rdy && ins_live.b.rdy;
  assign issue_go  = any_grant || bypass;

  // Lowest-numbered free slot.
  always_comb begin
    logic found;
    found   = 1'b0;
    free_oh = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!slot_busy[i] && !found) begin
        free_oh[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  assign slot_alloc = (ins_ok && !bypass) ? free_oh : '0;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    vrs_entry u_entry (
      .clk       (clk),
      .rst       (rst),
      .alloc     (slot_alloc[g]),
      .alloc_uop (ins_live),
      .drop      (slot_grant[g]),
      .bc_valid  (bc_valid),
      .bc_tag    (bc_tag),
      .bc_val    (bc_val),
      .busy      (slot_busy[g]),
      .ready     (slot_ready[g]),
      .live      (slot_live[g])
    );
  end

  vrs_age_pick #(.N(ENTRIES)) u_pick (
    .clk   (clk),
    .rst   (rst),
    .alloc (slot_alloc),
    .req   (slot_ready),
    .grant (slot_grant)
  );

  // AND-OR selection of the granted entry; bypass only when none granted.
  always_comb begin
    pick_bits = '0;
    for (int i = 0; i < ENTRIES; i++)
      pick_bits = pick_bits | (slot_live[i] & {UOP_W{slot_grant[i]}});
    pick_uop = bypass ? ins_live : uop_t'(pick_bits);
  end

  assign pick_rdy = {pick_uop.a.rdy, pick_uop.b.rdy};

  always_ff @(posedge clk) begin
    if (rst) iss_valid <= 1'b0;
    else     iss_valid <= issue_go;
  end

  always_ff @(posedge clk) begin
    if (issue_go) begin
      iss_op     <= pick_uop.op;
      iss_a      <= pick_uop.a.data;
      iss_b      <= pick_uop.b.data;
      iss_imm_en <= pick_uop.imm_en;
      iss_imm    <= pick_uop.imm;
      iss_dst    <= pick_uop.dst;
    end
  end
endmodule

// File: rtl/vrs_station_chk.sv
module vrs_station_chk
  import vrs_pkg::*;
#(
  parameter int ENTRIES = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               ins_valid,
  input logic               ins_a_rdy,
  input logic               ins_b_rdy,
  input logic [DATA_W-1:0]  ins_a_data,
  input logic [TAG_W-1:0]   ins_dst,
  input logic               full,
  input logic               iss_valid,
  input logic [TAG_W-1:0]   iss_dst,
  input logic [DATA_W-1:0]  iss_a,
  input logic [ENTRIES-1:0] slot_ready,
  input logic [ENTRIES-1:0] slot_grant,
  input logic               issue_go,
  input logic [1:0]         pick_rdy
);
  // Instructions accepted and not yet past the issue register, from ports.
  int cnt;
  always_ff @(posedge clk) begin
    if (rst) cnt <= 0;
    else     cnt <= cnt + int'(ins_valid && !full) - int'(iss_valid);
  end

  assert_one_grant_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(slot_grant));

  assert_grant_is_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (slot_grant & ~slot_ready) == '0);

  assert_issue_complete_R6: assert property (@(posedge clk) disable iff (rst)
    issue_go |-> pick_rdy == 2'b11);

  assert_full_tracks_R8: assert property (@(posedge clk) disable iff (rst)
    full == ((cnt - int'(iss_valid)) == ENTRIES));

  assert_full_ignores_R8: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && full && !(|slot_ready)) |=> !iss_valid);

  assert_bypass_empty_R2: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_a_rdy && ins_b_rdy && cnt == int'(iss_valid))
    |=> (iss_valid && iss_dst == $past(ins_dst) && iss_a == $past(ins_a_data)));

  assert_issue_owned_R10: assert property (@(posedge clk) disable iff (rst)
    iss_valid |-> cnt >= 1);
endmodule

bind vrs_station vrs_station_chk #(.ENTRIES(ENTRIES)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ins_valid  (ins_valid),
  .ins_a_rdy  (ins_a_rdy),
  .ins_b_rdy  (ins_b_rdy),
  .ins_a_data (ins_a_data),
  .ins_dst    (ins_dst),
  .full       (full),
  .iss_valid  (iss_valid),
  .iss_dst    (iss_dst),
  .iss_a      (iss_a),
  .slot_ready (slot_ready),
  .slot_grant (slot_grant),
  .issue_go   (issue_go),
  .pick_rdy   (pick_rdy)
);

// File: tb/vrs_station_tb_top.sv
module vrs_station_tb_top;
  import vrs_pkg::*;
  localparam int N = 4, DW = DATA_W, TW = TAG_W, OW = OP_W, NTAG = 1 << TAG_W;

  logic clk = 1'b0, rst = 1'b1;
  logic ins_valid, ins_a_rdy, ins_b_rdy, ins_imm_en, bc_valid;
  logic [OW-1:0] ins_op;
  logic [DW-1:0] ins_a_data, ins_b_data, ins_imm, bc_val;
  logic [TW-1:0] ins_dst, bc_tag;
  logic full, iss_valid, iss_imm_en;
  logic [OW-1:0] iss_op;
  logic [DW-1:0] iss_a, iss_b, iss_imm;
  logic [TW-1:0] iss_dst;

  vrs_station #(.ENTRIES(N)) dut_i (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_op(ins_op),
    .ins_a_rdy(ins_a_rdy), .ins_a_data(ins_a_data),
    .ins_b_rdy(ins_b_rdy), .ins_b_data(ins_b_data),
    .ins_imm_en(ins_imm_en), .ins_imm(ins_imm), .ins_dst(ins_dst),
    .full(full), .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b),
    .iss_imm_en(iss_imm_en), .iss_imm(iss_imm), .iss_dst(iss_dst));

  always #2 clk = ~clk;

  typedef struct {
    logic [OW-1:0] op; logic ar; logic [DW-1:0] a; logic br; logic [DW-1:0] b;
    logic ie; logic [DW-1:0] imm; logic [TW-1:0] dst;
  } ins_t;

  ins_t mq[$];
  ins_t exp_i;
  logic exp_v = 1'b0;
  bit   last_acc;
  int   n_cmp = 0, n_bad = 0;
  bit   done = 0;
  int   tstate [NTAG];
  int   bcq[$];

  function automatic ins_t wake(ins_t x);
    if (!x.ar && bc_valid && x.a[TW-1:0] == bc_tag) begin x.ar = 1'b1; x.a = bc_val; end
    if (!x.br && bc_valid && x.b[TW-1:0] == bc_tag) begin x.br = 1'b1; x.b = bc_val; end
    return x;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] expv);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic idle();
    ins_valid = 0; ins_op = '0; ins_a_rdy = 0; ins_a_data = '0; ins_b_rdy = 0;
    ins_b_data = '0; ins_imm_en = 0; ins_imm = '0; ins_dst = '0;
    bc_valid = 0; bc_tag = '0; bc_val = '0;
  endtask

  task automatic put(logic [OW-1:0] op, logic ar, logic [DW-1:0] a, logic br,
                     logic [DW-1:0] b, logic ie, logic [DW-1:0] imm, logic [TW-1:0] d);
    ins_valid = 1; ins_op = op; ins_a_rdy = ar; ins_a_data = a; ins_b_rdy = br;
    ins_b_data = b; ins_imm_en = ie; ins_imm = imm; ins_dst = d;
  endtask

  task automatic bcast(logic [TW-1:0] t, logic [DW-1:0] v);
    bc_valid = 1; bc_tag = t; bc_val = v;
  endtask

  // Behavioural model: age-ordered queue of waiting instructions.
  task automatic model_step();
    ins_t n;
    int pick = -1;
    for (int i = 0; i < mq.size(); i++) begin
      mq[i] = wake(mq[i]);
      if (pick < 0 && mq[i].ar && mq[i].br) pick = i;
    end
    n.op = ins_op; n.ar = ins_a_rdy; n.a = ins_a_data; n.br = ins_b_rdy; n.b = ins_b_data;
    n.ie = ins_imm_en; n.imm = ins_imm; n.dst = ins_dst;
    n = wake(n);
    last_acc = ins_valid && (mq.size() < N);
    exp_v = 1'b0;
    if (pick >= 0) begin
      exp_v = 1'b1; exp_i = mq[pick]; mq.delete(pick);
      if (last_acc) mq.push_back(n);
    end else if (last_acc && n.ar && n.br) begin
      exp_v = 1'b1; exp_i = n;
    end else if (last_acc) begin
      mq.push_back(n);
    end
  endtask

  task automatic advance();
    @(posedge clk);
    @(negedge clk);
    chk("R6", "issue valid", iss_valid, exp_v);
    if (exp_v && iss_valid) begin
      chk("R6", "issue dst", iss_dst, exp_i.dst);
      chk("R6", "issue op", iss_op, exp_i.op);
      chk("R6", "issue src a", iss_a, exp_i.a);
      chk("R6", "issue src b", iss_b, exp_i.b);
      chk("R10", "issue imm_en", iss_imm_en, exp_i.ie);
      if (exp_i.ie) chk("R10", "issue imm", iss_imm, exp_i.imm);
    end
    chk("R8", "full flag", full, mq.size() == N);
  endtask

  task automatic tick();
    model_step();
    advance();
  endtask

  task automatic book();
    if (last_acc) tstate[ins_dst] = 1;
    if (exp_v) begin bcq.push_back(int'(exp_i.dst)); tstate[exp_i.dst] = 2; end
  endtask

  task automatic run_random(int cycles);
    for (int t = 0; t < NTAG; t++) tstate[t] = 0;
    bcq.delete();
    for (int cyc = 0; cyc < cycles; cyc++) begin
      automatic int bct = -1;
      idle();
      if (bcq.size() > 0 && $urandom_range(0, 2) != 0) begin
        automatic int k = $urandom_range(0, bcq.size() - 1);
        bct = bcq[k];
        bcq.delete(k);
        bcast(bct[TW-1:0], $urandom);
      end
      if ($urandom_range(0, 9) < 6) begin
        automatic int fr[$];
        automatic int fl[$];
        for (int t = 0; t < NTAG; t++) begin
          if (tstate[t] == 0 && t != bct) fr.push_back(t);
          if (tstate[t] != 0) fl.push_back(t);
        end
        if (fr.size() > 0) begin
          automatic int d = fr[$urandom_range(0, fr.size() - 1)];
          automatic logic [DW-1:0] a = $urandom, b = $urandom;
          automatic logic ar = 1, br = 1;
          if (fl.size() > 0 && $urandom_range(0, 1) == 1) begin
            ar = 0; a[TW-1:0] = fl[$urandom_range(0, fl.size() - 1)];
          end
          if (fl.size() > 0 && $urandom_range(0, 2) == 0) begin
            br = 0; b[TW-1:0] = fl[$urandom_range(0, fl.size() - 1)];
          end
          put($urandom, ar, a, br, b, $urandom_range(0, 1) == 1, $urandom, d[TW-1:0]);
        end
      end
      model_step();
      book();
      if (bct >= 0) tstate[bct] = 0;
      advance();
    end
    for (int c = 0; c < 400 && (mq.size() > 0 || bcq.size() > 0 || exp_v); c++) begin
      automatic int bct = -1;
      idle();
      if (bcq.size() > 0) begin bct = bcq.pop_front(); bcast(bct[TW-1:0], $urandom); end
      model_step();
      book();
      if (bct >= 0) tstate[bct] = 0;
      advance();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1", "reset iss_valid", iss_valid, 0);
    chk("R1", "reset full", full, 0);

    // R2: ready insert into an idle station bypasses storage.
    put(6'd1, 1, 32'h0000_1111, 1, 32'h0000_2222, 0, '0, 4'd1);
    tick();
    chk("R2", "bypass valid", iss_valid, 1);
    chk("R2", "bypass dst", iss_dst, 1);
    idle(); tick();
    chk("R2", "bypass not stored", iss_valid, 0);

    // R3 and R4: tag in low bits, upper bits ignored; wake on match only.
    put(6'd2, 0, 32'hABCD_0003, 1, 32'h0000_0042, 0, '0, 4'd2);
    tick();
    chk("R4", "waiting holds", iss_valid, 0);
    idle(); bcast(4'd4, 32'h5555_5555); tick();
    chk("R4", "no wake on other tag", iss_valid, 0);
    idle(); bcast(4'd3, 32'h1234_5678); tick();
    chk("R4", "issue after broadcast", iss_valid, 1);
    chk("R3", "captured value", iss_a, 32'h1234_5678);

    // R5: broadcast in the insert cycle enables bypass.
    put(6'd3, 1, 32'h0000_0007, 0, 32'hFFFF_0005, 0, '0, 4'd3);
    bcast(4'd5, 32'h0BAD_F00D);
    tick();
    chk("R5", "same-cycle bypass", iss_valid, 1);
    chk("R5", "same-cycle value", iss_b, 32'h0BAD_F00D);

    // R7: ready stored entry wins over bypass.
    idle(); put(6'd4, 0, 32'h0000_0006, 1, 32'h0000_0001, 0, '0, 4'd4);
    tick();
    put(6'd5, 1, 32'h0000_0009, 1, 32'h0000_000A, 0, '0, 4'd5);
    bcast(4'd6, 32'h6666_0000);
    tick();
    chk("R7", "stored entry first", iss_dst, 4);
    chk("R7", "stored entry value", iss_a, 32'h6666_0000);
    idle(); tick();
    chk("R7", "insert issued later", iss_valid, 1);
    chk("R7", "insert dst later", iss_dst, 5);

    // R8 and R9: fill, refused insert, ordered drain.
    for (int k = 0; k < N; k++) begin
      idle(); put(6'd6, 0, 32'h0000_0009, 1, k, 0, '0, 4'(8 + k));
      tick();
    end
    chk("R8", "full after fill", full, 1);
    idle(); put(6'd7, 1, 32'h1, 1, 32'h2, 0, '0, 4'd12);
    tick();
    chk("R8", "refused insert no issue", iss_valid, 0);
    chk("R8", "still full", full, 1);
    idle(); bcast(4'd9, 32'h9999_9999); tick();
    chk("R6", "oldest first", iss_dst, 8);
    chk("R9", "full drops on issue", full, 0);
    for (int k = 1; k < N; k++) begin
      idle(); tick();
      chk("R6", "age order", iss_dst, 8 + k);
    end
    idle(); tick();
    chk("R8", "refused insert never issues", iss_valid, 0);

    // R10: constant delivered once.
    put(6'd8, 1, 32'h3, 1, 32'h4, 1, 32'h0000_CAFE, 4'd13);
    tick();
    chk("R10", "imm enable", iss_imm_en, 1);
    chk("R10", "imm value", iss_imm, 32'h0000_CAFE);
    idle(); tick();
    chk("R10", "issued once", iss_valid, 0);

    // Random dependency chains against the model (R4 R5 R6 R7 R8 R10).
    run_random(4000);
    idle(); tick();
    chk("R10", "all drained", iss_valid, 0);
    chk("R8", "empty at end", full, 0);
    finish_run();
  end
endmodule